// File: doc/BRIEF.md
# Atomic Ownership Request Gate

This block sits in front of a cache request sequencer that several processors share. Each cycle it decides whether the incoming request may proceed. It also keeps track of which processor holds the exclusive atomic window and how many read-modify-write pairs that processor still has open. A processor opens the window with a read-modify-write read. While the window is open, requests from every other processor are refused. The window closes in one of two ways: the completions of the matching read-modify-write writes bring the count back to zero, or the owner issues an ordinary access.

The gate also reports the cache request class that an accepted request is issued under downstream. All locked and read-modify-write kinds fold into one atomic class. Protocol violations raise a sticky error flag and leave the ownership state as it was. A probe flag asks for the accept decision without committing any state change. When a completion and a request arrive in the same cycle, the completion is applied first.

Top module: `atomic_gate`

## Requirements
- R1: After reset there is no owner, the open-pair count is zero and the error flag is low. While the window is unowned, any request from a legal processor is accepted.
- R2: While a processor owns the window, `req_accept` is low for every request whose processor ID differs from the owner's.
- R3: An accepted, non-probe read-modify-write read (kind 5) made while nobody owns the window makes the requester the owner, with one open pair.
- R4: Each accepted, non-probe read-modify-write read from the owner adds one open pair. A read-modify-write write request from the owner (kind 6) is accepted and changes nothing.
- R5: A non-probe request from the owner of any other kind is accepted and releases the window at once. These kinds are load 0, store 1, ifetch 2, locked read 3, locked write 4 and spare 7.
- R6: A completion of kind 6 from the owner removes one open pair, and removing the last pair releases the window. Completions of any other kind have no effect.
- R7: With `req_probe` high, `req_accept` shows the same decision as a normal request, but the owner and the count stay unchanged.
- R8: `req_class` encodes load as 0, store and spare as 1, ifetch as 2, and locked read, locked write, read-modify-write read and read-modify-write write as 3 (atomic).
- R9: Processor IDs 100 and 200 are illegal on the request input. Such a request is refused and raises the error flag.
- R10: A kind 6 completion from a non-owner, or one that arrives with zero open pairs, raises the error flag and leaves the state unchanged.
- R11: A non-probe read-modify-write read from the owner while the count is at its maximum (15 by default) is refused and raises the error flag. A probe in the same situation is refused without raising the error flag.
- R12: When a completion and a request arrive in the same cycle, the request is decided against the state as it stands after the completion.
- R13: `req_accept` and `req_class` respond within the cycle of the request. The error flag rises on the next clock edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_proc | input | PID_W | Requesting processor ID |
| req_kind | input | 3 | Request kind code |
| req_probe | input | 1 | Ask for the decision only, commit nothing |
| cpl_valid | input | 1 | A completion is reported this cycle |
| cpl_kind | input | 3 | Kind code of the completed request |
| cpl_proc | input | PID_W | Processor ID of the completed request |
| req_accept | output | 1 | The request may proceed |
| req_class | output | 2 | Downstream cache request class |
| err_flag | output | 1 | Sticky protocol-violation flag |

## Verification
`req_accept` and `req_class` are combinational, so they are due in the same cycle as the request. The error flag is registered and is due one edge later. The bench drives its inputs just after a falling edge and samples two nanoseconds later, before the next rising edge. At that point, the expected accept and class belong to the present stimulus, while the expected error value is the one the reference model had built up over all earlier cycles. The model applies the effects of the current cycle only after the expected item for that cycle has been queued.

// File: rtl/atomic_gate_pkg.sv
// Package: shared codes for the atomic ownership gate.
// Assumes kind and class codes are fixed by the neighbouring sequencer.
package atomic_gate_pkg;

    typedef enum logic [2:0] {
        KIND_LOAD    = 3'd0,
        KIND_STORE   = 3'd1,
        KIND_IFETCH  = 3'd2,
        KIND_LOCK_RD = 3'd3,
        KIND_LOCK_WR = 3'd4,
        KIND_RMW_RD  = 3'd5,
        KIND_RMW_WR  = 3'd6,
        KIND_SPARE   = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        CLS_LOAD   = 2'd0,
        CLS_STORE  = 2'd1,
        CLS_IFETCH = 2'd2,
        CLS_ATOMIC = 2'd3
    } cache_cls_e;

endpackage

// File: rtl/atomic_gate_class_map.sv
// Module: maps a request kind onto the downstream cache request class.
// Purely combinational. All locked and read-modify-write kinds share the
// atomic class. The spare code is issued as a store.
module atomic_gate_class_map
    import atomic_gate_pkg::*;
(
    input  logic [2:0] kind,
    output logic [1:0] cls
);

    req_kind_e  kind_e;
    cache_cls_e cls_e;

    assign kind_e = req_kind_e'(kind);

    // Decode the kind into its class.
    always_comb begin
        unique case (kind_e)
            KIND_LOAD:    cls_e = CLS_LOAD;
            KIND_IFETCH:  cls_e = CLS_IFETCH;
            KIND_LOCK_RD,
            KIND_LOCK_WR,
            KIND_RMW_RD,
            KIND_RMW_WR:  cls_e = CLS_ATOMIC;
            default:      cls_e = CLS_STORE;
        endcase
    end

    assign cls = cls_e;

endmodule

// File: rtl/atomic_gate_retire.sv
// Module: applies a completion report to the ownership state.
// Combinational. Only read-modify-write write completions change the state.
// A completion that breaks the invariants (wrong processor, nothing open)
// is flagged and leaves the state untouched.
module atomic_gate_retire
    import atomic_gate_pkg::*;
#(
    parameter int PID_W       = 8,
    parameter int CNT_W       = 4,
    parameter int NO_OWNER_ID = 200
) (
    input  logic [PID_W-1:0] owner_q,
    input  logic [CNT_W-1:0] count_q,
    input  logic             cpl_valid,
    input  logic [2:0]       cpl_kind,
    input  logic [PID_W-1:0] cpl_proc,
    output logic [PID_W-1:0] owner_mid,
    output logic [CNT_W-1:0] count_mid,
    output logic             cpl_err
);

    localparam logic [PID_W-1:0] NONE_ID = PID_W'(NO_OWNER_ID);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic is_wr_done;

    assign is_wr_done = cpl_valid && (req_kind_e'(cpl_kind) == KIND_RMW_WR);
    assign cpl_err    = is_wr_done && ((cpl_proc != owner_q) || (count_q == '0));

    // Retire one open pair; the last one hands the window back.
    always_comb begin
        owner_mid = owner_q;
        count_mid = count_q;
        if (is_wr_done && !cpl_err) begin
            count_mid = count_q - ONE;
            if (count_q == ONE) begin
                owner_mid = NONE_ID;
            end
        end
    end

endmodule

// File: rtl/atomic_gate_arbiter.sv
// Module: decides on one request against the post-completion state and
// computes the next ownership state.
// Combinational. Assumes owner_mid/count_mid already include any
// completion of the same cycle. Probe requests commit nothing.
module atomic_gate_arbiter
    import atomic_gate_pkg::*;
#(
    parameter int PID_W       = 8,
    parameter int CNT_W       = 4,
    parameter int NO_OWNER_ID = 200,
    parameter int BAD_ID      = 100
) (
    input  logic [PID_W-1:0] owner_mid,
    input  logic [CNT_W-1:0] count_mid,
    input  logic             req_valid,
    input  logic [PID_W-1:0] req_proc,
    input  logic [2:0]       req_kind,
    input  logic             req_probe,
    output logic             grant,
    output logic             req_err,
    output logic [PID_W-1:0] owner_nxt,
    output logic [CNT_W-1:0] count_nxt
);

    localparam logic [PID_W-1:0] NONE_ID = PID_W'(NO_OWNER_ID);
    localparam logic [PID_W-1:0] ILL_ID  = PID_W'(BAD_ID);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    req_kind_e kind_e;
    logic      id_bad;
    logic      blocked;
    logic      is_rd;
    logic      is_wr;
    logic      full;
    logic      commit;

    assign kind_e  = req_kind_e'(req_kind);
    assign is_rd   = (kind_e == KIND_RMW_RD);
    assign is_wr   = (kind_e == KIND_RMW_WR);
    assign id_bad  = (req_proc == ILL_ID) || (req_proc == NONE_ID);
    assign blocked = (owner_mid != NONE_ID) && (owner_mid != req_proc);
    assign full    = is_rd && (count_mid == CNT_MAX);

    assign grant   = req_valid && !id_bad && !blocked && !full;
    assign req_err = req_valid && (id_bad || (full && !blocked && !req_probe));
    assign commit  = grant && !req_probe;

    // Open, extend or release the window for a committed request.
    always_comb begin
        owner_nxt = owner_mid;
        count_nxt = count_mid;
        if (commit) begin
            if (is_rd) begin
                owner_nxt = req_proc;
                count_nxt = count_mid + ONE;
            end else if (!is_wr && (owner_mid == req_proc)) begin
                owner_nxt = NONE_ID;
                count_nxt = '0;
            end
        end
    end

endmodule

// File: rtl/atomic_gate.sv
// Module: atomic ownership request gate (top).
// Holds the window owner, the open-pair count and a sticky error flag.
// Accept and class are combinational within the request cycle, and the
// error flag registers on the following edge. Completions are applied
// before the request of the same cycle is decided. PID_W must be at least 8.
module atomic_gate
    import atomic_gate_pkg::*;
#(
    parameter int PID_W       = 8,
    parameter int CNT_W       = 4,
    parameter int NO_OWNER_ID = 200,
    parameter int BAD_ID      = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PID_W-1:0] req_proc,
    input  logic [2:0]       req_kind,
    input  logic             req_probe,
    input  logic             cpl_valid,
    input  logic [2:0]       cpl_kind,
    input  logic [PID_W-1:0] cpl_proc,
    output logic             req_accept,
    output logic [1:0]       req_class,
    output logic             err_flag
);

    localparam logic [PID_W-1:0] NONE_ID = PID_W'(NO_OWNER_ID);
    localparam logic [PID_W-1:0] ILL_ID  = PID_W'(BAD_ID);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [PID_W-1:0] owner_q, owner_mid, owner_nxt;
    logic [CNT_W-1:0] count_q, count_mid, count_nxt;
    logic             err_q;
    logic             cpl_err, req_err;

    atomic_gate_retire #(
        .PID_W(PID_W), .CNT_W(CNT_W), .NO_OWNER_ID(NO_OWNER_ID)
    ) u_retire (
        .owner_q   (owner_q),
        .count_q   (count_q),
        .cpl_valid (cpl_valid),
        .cpl_kind  (cpl_kind),
        .cpl_proc  (cpl_proc),
        .owner_mid (owner_mid),
        .count_mid (count_mid),
        .cpl_err   (cpl_err)
    );

    atomic_gate_arbiter #(
        .PID_W(PID_W), .CNT_W(CNT_W), .NO_OWNER_ID(NO_OWNER_ID), .BAD_ID(BAD_ID)
    ) u_arbiter (
        .owner_mid (owner_mid),
        .count_mid (count_mid),
        .req_valid (req_valid),
        .req_proc  (req_proc),
        .req_kind  (req_kind),
        .req_probe (req_probe),
        .grant     (req_accept),
        .req_err   (req_err),
        .owner_nxt (owner_nxt),
        .count_nxt (count_nxt)
    );

    atomic_gate_class_map u_class (
        .kind (req_kind),
        .cls  (req_class)
    );

    // Ownership state register; reset opens with no owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= NONE_ID;
            count_q <= '0;
        end else begin
            owner_q <= owner_nxt;
            count_q <= count_nxt;
        end
    end

    // Sticky error: any violation latches until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_q | cpl_err | req_err;
        end
    end

    assign err_flag = err_q;

    // R1: an unowned window never carries open pairs, and an owned one always does.
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == NONE_ID) == (count_q == '0));

    // R2: another processor is refused while the window is held.
    p_refuse_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cpl_valid && owner_q != NONE_ID && req_proc != owner_q)
        |-> !req_accept);

    // R3: an accepted opening read makes the requester the owner.
    p_take_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept && !req_probe && !cpl_valid &&
         req_kind == 3'd5 && owner_q == NONE_ID)
        |=> (owner_q == $past(req_proc)) && (count_q == ONE));

    // R7: a probe leaves the ownership state untouched.
    p_probe_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe && !cpl_valid)
        |=> ($stable(owner_q) && $stable(count_q)));

    // R8: locked and read-modify-write kinds go out in the atomic class.
    p_atomic_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind >= 3'd3 && req_kind <= 3'd6) |-> (req_class == 2'd3));

    // R9: an illegal processor ID is never accepted.
    p_bad_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_proc == ILL_ID || req_proc == NONE_ID)) |-> !req_accept);

    // R13: the error flag holds once raised.
    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: tb/atomic_gate_tb.sv
// Scoreboard bench: the driver queues expected items from a reference model,
// and the monitor pops them and compares them with the outputs.
module atomic_gate_tb;

    localparam int PID_W   = 8;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int NONE    = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [PID_W-1:0] req_proc = '0;
    logic [2:0]       req_kind = '0;
    logic             req_probe = 1'b0;
    logic             cpl_valid = 1'b0;
    logic [2:0]       cpl_kind = '0;
    logic [PID_W-1:0] cpl_proc = '0;
    logic             req_accept;
    logic [1:0]       req_class;
    logic             err_flag;

    atomic_gate #(.PID_W(PID_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_proc(req_proc), .req_kind(req_kind),
        .req_probe(req_probe), .cpl_valid(cpl_valid), .cpl_kind(cpl_kind),
        .cpl_proc(cpl_proc), .req_accept(req_accept), .req_class(req_class),
        .err_flag(err_flag)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit    acc;
        int    cls;
        bit    err;
        string tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;

    int m_owner = NONE;
    int m_cnt = 0;
    bit m_err = 0;

    function automatic int cls_of(int k);
        if (k == 0) return 0;
        if (k == 2) return 2;
        if (k >= 3 && k <= 6) return 3;
        return 1;
    endfunction

    // Monitor: pop and compare every queued item.
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (req_accept !== e.acc || int'(req_class) != e.cls || err_flag !== e.err) begin
                    fails++;
                    $display("FAIL %s: acc/cls/err actual %b/%0d/%b expected %b/%0d/%b",
                             e.tag, req_accept, req_class, err_flag, e.acc, e.cls, e.err);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        cpl_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_owner = NONE;
        m_cnt = 0;
        m_err = 0;
    endtask

    // Driver: apply one cycle, queue the expected result, advance the model.
    task automatic step(input bit rv, input int rp, input int rk, input bit pr,
                        input bit cv, input int ck, input int cp, input string tag);
        int   o;
        int   c;
        bit   cerr;
        bit   bad;
        bit   blk;
        bit   full;
        bit   acc;
        bit   rerr;
        exp_t e;
        @(negedge clk);
        req_valid = rv;
        req_proc  = PID_W'(rp);
        req_kind  = 3'(rk);
        req_probe = pr;
        cpl_valid = cv;
        cpl_kind  = 3'(ck);
        cpl_proc  = PID_W'(cp);
        #2;
        o = m_owner;
        c = m_cnt;
        cerr = 0;
        if (cv && ck == 6) begin
            if (cp != m_owner || m_cnt == 0) cerr = 1;
            else begin
                c = m_cnt - 1;
                if (c == 0) o = NONE;
            end
        end
        bad  = (rp == 100) || (rp == NONE);
        blk  = (o != NONE) && (o != rp);
        full = (rk == 5) && (c == CNT_MAX);
        acc  = rv && !bad && !blk && !full;
        rerr = rv && (bad || (full && !blk && !pr));
        e.acc = acc;
        e.cls = cls_of(rk);
        e.err = m_err;
        e.tag = tag;
        q.push_back(e);
        ->sample_ev;
        if (acc && !pr) begin
            if (rk == 5) begin
                o = rp;
                c = c + 1;
            end else if (o == rp && rk != 6) begin
                o = NONE;
                c = 0;
            end
        end
        m_owner = o;
        m_cnt = c;
        m_err = m_err | cerr | rerr;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
        step(1, 3, 0, 0, 0, 0, 0, "R1 load accepted when unowned");
        step(1, 3, 5, 0, 0, 0, 0, "R3 opening read");
        step(1, 5, 1, 0, 0, 0, 0, "R2 store from other refused");
        step(1, 3, 5, 0, 0, 0, 0, "R4 nested read");
        step(1, 5, 0, 0, 1, 6, 3, "R6 one pair retired, still owned");
        step(1, 5, 0, 0, 1, 6, 3, "R12 completion first then accept");
        step(1, 5, 5, 0, 0, 0, 0, "R3 new owner");
        step(1, 7, 5, 1, 0, 0, 0, "R7 probe from other refused");
        step(1, 5, 5, 1, 0, 0, 0, "R7 probe from owner accepted");
        step(0, 0, 0, 0, 1, 0, 5, "R6 non-write completion ignored");
        step(1, 7, 2, 0, 0, 0, 0, "R2 ifetch from other refused");
        step(0, 0, 0, 0, 1, 6, 5, "R6 last pair retired");
        step(1, 7, 2, 0, 0, 0, 0, "R7 probe added no pair");
        step(1, 7, 5, 0, 0, 0, 0, "R3 owner 7");
        step(1, 7, 3, 0, 0, 0, 0, "R5 locked read releases");
        step(1, 9, 4, 0, 0, 0, 0, "R5 locked write from new proc");
        step(1, 9, 5, 0, 0, 0, 0, "R3 owner 9");
        step(1, 9, 6, 0, 0, 0, 0, "R4 owner write request keeps window");
        step(1, 2, 1, 0, 0, 0, 0, "R4 window still held");
        step(1, 2, 7, 0, 0, 0, 0, "R8 spare class refused");
        for (int i = 0; i < CNT_MAX - 1; i++) step(1, 9, 5, 0, 0, 0, 0, "R4 fill count");
        step(1, 9, 5, 1, 0, 0, 0, "R11 probe at full refused");
        step(0, 0, 0, 0, 0, 0, 0, "R11 probe raised no error");
        step(1, 9, 5, 0, 0, 0, 0, "R11 read at full refused");
        step(0, 0, 0, 0, 0, 0, 0, "R11 error raised");
        step(1, 9, 1, 0, 0, 0, 0, "R5 store releases full window");
        step(1, 4, 5, 0, 0, 0, 0, "R13 error still set");
        step(0, 0, 0, 0, 1, 6, 6, "R10 completion from non-owner");
        step(1, 6, 0, 0, 0, 0, 0, "R10 owner unchanged");
        do_reset();
        step(0, 0, 0, 0, 0, 0, 0, "R1 error cleared by reset");
        step(1, 100, 0, 0, 0, 0, 0, "R9 id 100 refused");
        step(0, 0, 0, 0, 0, 0, 0, "R9 error raised");
        do_reset();
        step(1, 200, 2, 0, 0, 0, 0, "R9 id 200 refused");
        step(1, 8, 0, 0, 0, 0, 0, "R9 state unchanged");
        do_reset();
        step(0, 0, 0, 0, 1, 6, 4, "R10 completion with nothing open");
        step(1, 4, 5, 0, 0, 0, 0, "R10 error set, state still unowned");
        step(1, 11, 0, 0, 0, 0, 0, "R8 load class");
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule